// File: doc/BRIEF.md
# Oversampled Nibble Trace Capture Receiver

This block takes in a branch-trace stream from the debug port of a target processor. The port has three parts: a clock driven by the target, an active-low frame strobe and a 4-bit data bus. The target moves one nibble onto the bus for each cycle of its trace clock. The nibbles of one strobe-delimited frame together form the destination address of a jump, branch or call that changed the target's program counter.

The target clock is never used as a clock inside the block. The block samples all six lines with its own local clock, which must run at least four times the trace clock rate. Each line first passes through a two-flop synchronizer. The block then looks for 0-to-1 transitions of the synchronized trace clock, and collects one nibble at each such transition while the strobe is low.

When the strobe is seen high at a later trace-clock rise, the block closes the frame. It places the rebuilt address and the number of nibbles in a one-entry output register, which a consumer drains through a valid/ready handshake. Two sticky flags record two conditions: frames lost because the output register was still full, and frames that carried more nibbles than an address holds.

Top module: `trace_nibble_rx`

## Requirements
- R1: After reset (rst_n low at a clock edge), valid_o, ovf_o and err_o are 0, and addr_o and nib_cnt_o are 0. A reset also clears a previously set overflow or error flag.
- R2: For a frame of 8 nibbles, addr_o equals the nibbles concatenated with the first received nibble in bits 31:28, and nib_cnt_o is 8. Within each nibble, data bit 3 is the most significant bit.
- R3: For a frame of N < 8 nibbles, addr_o holds the nibbles right-aligned in bits 4N-1:0, with the first nibble most significant and all upper bits 0. nib_cnt_o is N.
- R4: Trace-clock rises while the strobe is high add no nibble, whatever the data bus carries.
- R5: Only a 0-to-1 transition of the synchronized trace clock captures a nibble. Data changes while the trace clock stays high are not captured.
- R6: While valid_o is 1 and ready_i is 0, valid_o stays 1 and addr_o and nib_cnt_o stay unchanged.
- R7: If a frame closes while valid_o is 1 and ready_i is 0, that frame is dropped, the pending address is kept and ovf_o becomes 1. ovf_o stays 1 until reset.
- R8: In a frame of more than 8 nibbles, the first 8 are kept and the rest are discarded. The frame is still delivered with nib_cnt_o = 8, and err_o becomes 1 and stays 1 until reset.
- R9: A frame closes only at a trace-clock rise with the strobe high that comes after at least one captured nibble. Strobe-high rises with no captured nibbles produce no output.
- R10: A cycle with valid_o and ready_i both 1 consumes the entry, so valid_o is 0 afterwards unless a new frame loads in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, at least 4x the trace clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_clk_i | input | 1 | Trace clock from target, asynchronous |
| tgt_sync_n_i | input | 1 | Active-low frame strobe from target, asynchronous |
| tgt_data_i | input | 4 | Trace nibble, bit 3 most significant |
| addr_o | output | 32 | Rebuilt destination address, right-aligned |
| nib_cnt_o | output | 4 | Number of nibbles in the delivered frame |
| valid_o | output | 1 | Output register holds an address |
| ready_i | input | 1 | Consumer accepts the address |
| ovf_o | output | 1 | Sticky: a frame was dropped while output was full |
| err_o | output | 1 | Sticky: a frame carried more than 8 nibbles |

## Verification
The packing function is tried with three kinds of frame, each aimed at a different fault. A full 8-nibble frame with distinct nibbles exposes swapped nibble order or swapped bit order. A 3-nibble frame tells right-alignment apart from left-alignment and shows whether the count is correct. A 10-nibble frame shows whether the surplus nibbles are dropped or whether they push out the first ones. Further patterns separate edge detection from level sampling: a long high phase of the trace clock during which the data changes, and junk data with the strobe high. Frames sent while the output register is still full show that an overflow keeps the old address rather than the new one.

// File: rtl/trace_rx_pkg.sv
// Package: default dimensions of the trace capture receiver.
// Assumes nothing; holds constants shared by the modules and the checker.
package trace_rx_pkg;
    localparam int NIB_W_DEF    = 4;
    localparam int MAX_NIBS_DEF = 8;
    localparam int SYNC_STG_DEF = 2;
endpackage

// File: rtl/trc_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is a quasi-static level or slow toggle relative to clk;
// bits are not coherent with each other beyond what oversampling provides.
module trc_sync #(
    parameter int          W      = 6,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain [STAGES];

    // First stage: capture asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= async_i;
    end

    // Further stages: shift toward the output to settle metastability.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/trc_packer.sv
// Module: collects nibbles on detected trace-clock rises while the strobe is
// low and closes the frame on a rise with the strobe high.
// Assumes rise_i is a one-cycle pulse and nib_i/sync_n_i are synchronized.
module trc_packer #(
    parameter int NIB_W    = 4,
    parameter int MAX_NIBS = 8,
    parameter int ADDR_W   = NIB_W * MAX_NIBS,
    parameter int CNT_W    = $clog2(MAX_NIBS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              sync_n_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              err_o
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_NIBS);

    logic [ADDR_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;

    // Frame assembly: shift in nibbles, flag surplus, hand off at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
            done_o  <= 1'b0;
            addr_o  <= '0;
            cnt_o   <= '0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (rise_i) begin
                if (!sync_n_i) begin
                    if (cnt_q < MAX_C) begin
                        shift_q <= {shift_q[ADDR_W-NIB_W-1:0], nib_i};
                        cnt_q   <= cnt_q + 1'b1;
                    end else begin
                        err_o <= 1'b1;
                    end
                end else if (cnt_q != '0) begin
                    done_o  <= 1'b1;
                    addr_o  <= shift_q;
                    cnt_o   <= cnt_q;
                    shift_q <= '0;
                    cnt_q   <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/trc_out_slot.sv
// Module: one-entry output register with valid/ready and sticky overflow.
// Assumes done_i is a one-cycle pulse; a frame arriving while full is lost.
module trc_out_slot #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_o
);
    // Entry load, consume and overflow tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            cnt_o   <= '0;
            ovf_o   <= 1'b0;
        end else begin
            if (valid_o && ready_i) valid_o <= 1'b0;
            if (done_i) begin
                if (valid_o && !ready_i) begin
                    ovf_o <= 1'b1;
                end else begin
                    valid_o <= 1'b1;
                    addr_o  <= addr_i;
                    cnt_o   <= cnt_i;
                end
            end
        end
    end
endmodule

// File: rtl/trace_nibble_rx.sv
// Module: top of the oversampled trace receiver. Synchronizes the port lines,
// detects trace-clock rises, assembles frames and presents the address.
// Assumes clk runs at least four times the trace clock rate.
module trace_nibble_rx
    import trace_rx_pkg::*;
#(
    parameter int NIB_W    = NIB_W_DEF,
    parameter int MAX_NIBS = MAX_NIBS_DEF,
    parameter int SYNC_STG = SYNC_STG_DEF,
    parameter int ADDR_W   = NIB_W * MAX_NIBS,
    parameter int CNT_W    = $clog2(MAX_NIBS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_clk_i,
    input  logic              tgt_sync_n_i,
    input  logic [NIB_W-1:0]  tgt_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  nib_cnt_o,
    output logic              valid_o,
    input  logic              ready_i,
    output logic              ovf_o,
    output logic              err_o
);
    localparam int BUS_W = NIB_W + 2;
    localparam logic [BUS_W-1:0] BUS_RST = {1'b0, 1'b1, {NIB_W{1'b0}}};

    logic [BUS_W-1:0]  bus_s;
    logic              tclk_s, sync_n_s, tclk_d, rise;
    logic [NIB_W-1:0]  nib_s;
    logic              done;
    logic [ADDR_W-1:0] frame_addr;
    logic [CNT_W-1:0]  frame_cnt;

    trc_sync #(.W(BUS_W), .STAGES(SYNC_STG), .RST_VAL(BUS_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({tgt_clk_i, tgt_sync_n_i, tgt_data_i}),
        .sync_o(bus_s)
    );

    assign {tclk_s, sync_n_s, nib_s} = bus_s;

    // Previous synchronized trace-clock sample for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tclk_d <= 1'b0;
        else        tclk_d <= tclk_s;
    end

    assign rise = tclk_s & ~tclk_d;

    trc_packer #(.NIB_W(NIB_W), .MAX_NIBS(MAX_NIBS), .ADDR_W(ADDR_W),
                 .CNT_W(CNT_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .sync_n_i(sync_n_s),
        .nib_i(nib_s), .done_o(done), .addr_o(frame_addr),
        .cnt_o(frame_cnt), .err_o(err_o)
    );

    trc_out_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .done_i(done), .addr_i(frame_addr),
        .cnt_i(frame_cnt), .ready_i(ready_i), .valid_o(valid_o),
        .addr_o(addr_o), .cnt_o(nib_cnt_o), .ovf_o(ovf_o)
    );
endmodule

// File: rtl/trace_nibble_rx_chk.sv
// Module: property checker for trace_nibble_rx, bound to every instance.
// Assumes only the top-level ports of the receiver.
module trace_nibble_rx_chk #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 4,
    parameter int MAX_NIBS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_o,
    input logic [CNT_W-1:0]  nib_cnt_o,
    input logic              valid_o,
    input logic              ready_i,
    input logic              ovf_o,
    input logic              err_o
);
    // R6: a pending entry is held stable until accepted.
    a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(nib_cnt_o)));

    // R7: overflow rises only when an entry was pending and not taken.
    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> ($past(valid_o) && !$past(ready_i)));

    // R7: overflow flag is sticky.
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R8: error flag is sticky.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R3: a delivered frame has between 1 and MAX_NIBS nibbles.
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (nib_cnt_o != '0 && nib_cnt_o <= CNT_W'(MAX_NIBS)));
endmodule

bind trace_nibble_rx trace_nibble_rx_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_NIBS(MAX_NIBS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_o(addr_o), .nib_cnt_o(nib_cnt_o),
    .valid_o(valid_o), .ready_i(ready_i), .ovf_o(ovf_o), .err_o(err_o)
);

// File: tb/trace_nibble_rx_test.sv
module trace_nibble_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_clk = 1'b0;
    logic        tgt_sync_n = 1'b1;
    logic [3:0]  tgt_data = 4'h0;
    logic        ready = 1'b0;
    logic [31:0] addr;
    logic [3:0]  cnt;
    logic        valid, ovf, err;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_nibble_rx uut (
        .clk(clk), .rst_n(rst_n), .tgt_clk_i(tgt_clk),
        .tgt_sync_n_i(tgt_sync_n), .tgt_data_i(tgt_data),
        .addr_o(addr), .nib_cnt_o(cnt), .valid_o(valid), .ready_i(ready),
        .ovf_o(ovf), .err_o(err)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tgt_clk = 1'b0; tgt_sync_n = 1'b1; tgt_data = 4'h0; ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One trace-clock period: data and strobe set while low, rise after HALF.
    task automatic tclk_cycle(input logic [3:0] d, input logic s);
        @(negedge clk);
        tgt_data = d; tgt_sync_n = s; tgt_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        tgt_clk = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [63:0] val, input int n);
        for (int i = 0; i < n; i++) tclk_cycle(val[4*(n-1-i) +: 4], 1'b0);
        tclk_cycle(4'h0, 1'b1);
        tclk_cycle(4'h0, 1'b1);
        repeat (6) @(negedge clk);
        #1;
    endtask

    task automatic pop();
        @(negedge clk); ready = 1'b1;
        @(negedge clk); ready = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset(); #1;
        check("R1 valid", {31'd0, valid}, 32'd0);
        check("R1 ovf", {31'd0, ovf}, 32'd0);
        check("R1 err", {31'd0, err}, 32'd0);
        check("R1 addr", addr, 32'd0);
        check("R1 cnt", {28'd0, cnt}, 32'd0);
    endtask

    task automatic t_full();
        send_frame(64'h8C00_1234, 8);
        check("R2 valid", {31'd0, valid}, 32'd1);
        check("R2 addr", addr, 32'h8C00_1234);
        check("R2 cnt", {28'd0, cnt}, 32'd8);
        pop();
        check("R10 valid after handshake", {31'd0, valid}, 32'd0);
    endtask

    task automatic t_short();
        send_frame(64'hA5C, 3);
        check("R3 addr", addr, 32'h0000_0A5C);
        check("R3 cnt", {28'd0, cnt}, 32'd3);
        pop();
    endtask

    task automatic t_ignore();
        for (int i = 0; i < 4; i++) tclk_cycle(4'hF, 1'b1);
        repeat (6) @(negedge clk); #1;
        check("R9 no frame without nibbles", {31'd0, valid}, 32'd0);
        send_frame(64'h3C, 2);
        check("R4 strobe-high data ignored", addr, 32'h0000_003C);
        check("R4 cnt", {28'd0, cnt}, 32'd2);
        pop();
    endtask

    task automatic t_edge();
        @(negedge clk);
        tgt_data = 4'h7; tgt_sync_n = 1'b0; tgt_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        tgt_clk = 1'b1;
        repeat (8) @(negedge clk);
        tgt_data = 4'h2;
        repeat (12) @(negedge clk);
        tclk_cycle(4'h1, 1'b0);
        tclk_cycle(4'h0, 1'b1);
        tclk_cycle(4'h0, 1'b1);
        repeat (6) @(negedge clk); #1;
        check("R5 edge-only capture addr", addr, 32'h0000_0071);
        check("R5 edge-only capture cnt", {28'd0, cnt}, 32'd2);
        pop();
    endtask

    task automatic t_hold_ovf();
        send_frame(64'hBEEF, 4);
        repeat (20) @(negedge clk); #1;
        check("R6 still valid", {31'd0, valid}, 32'd1);
        check("R6 addr held", addr, 32'h0000_BEEF);
        send_frame(64'h1111, 4);
        check("R7 ovf set", {31'd0, ovf}, 32'd1);
        check("R7 old addr kept", addr, 32'h0000_BEEF);
        pop();
        repeat (10) @(negedge clk); #1;
        check("R7 ovf sticky", {31'd0, ovf}, 32'd1);
        check("R10 empty after pop", {31'd0, valid}, 32'd0);
    endtask

    task automatic t_err();
        do_reset(); #1;
        check("R1 ovf cleared by reset", {31'd0, ovf}, 32'd0);
        send_frame(64'h01_2345_6789, 10);
        check("R8 first 8 kept", addr, 32'h0123_4567);
        check("R8 cnt", {28'd0, cnt}, 32'd8);
        check("R8 err set", {31'd0, err}, 32'd1);
        pop();
        send_frame(64'h5, 1);
        check("R8 err sticky", {31'd0, err}, 32'd1);
        check("R3 single nibble", addr, 32'h0000_0005);
        pop();
    endtask

    initial begin
        t_reset();
        t_full();
        t_short();
        t_ignore();
        t_edge();
        t_hold_ovf();
        t_err();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule